// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command front end and embedded-operation sequencer of a single-supply parallel NOR flash, scaled down to a small register array. The host drives a byte-wide bus with active-low chip-enable, write-enable and output-enable. A write cycle is a clock cycle with chip-enable and write-enable low and output-enable high. A read cycle is a clock cycle with chip-enable and output-enable low and write-enable high. The write cycles feed a state machine that recognises the unlock sequences and then starts a timed program or a timed sector erase.

While an operation runs, the `ready` output is low. A read returns a status byte in place of array data: bit 7 shows the complement of the programmed bit 7, and bit 6 flips on every status read. A shortcut mode cuts programming down to two bus writes. Per-sector protect inputs and a low-supply inhibit input block changes to the array.

Top module: `nor_flash_cmd`

## Requirements
- R1: After reset, `ready` is 1, every array byte reads 0xFF, the status toggle bit is 0, and the machine is in read mode. A read cycle latches `rdata` at the clock edge that samples it, so the value appears one cycle after the read is driven.
- R2: A normal program is four write cycles: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the target address and data. The stored byte becomes the old byte AND the data, so programming only clears bits.
- R3: `ready` goes low at the edge that takes the final command write. It stays low for exactly PROG_CYC cycles for a program, and for exactly PRE_CYC+ERASE_CYC cycles for a sector erase. It then returns high.
- R4: A read cycle while busy returns a status byte with bits 5..0 at zero. During a program, bit 7 is the complement of bit 7 of the data being programmed. During an erase, bit 7 is 0. Once the operation is over, reads return array data.
- R5: Status bit 6 is 0 after reset and inverts on every status read. It is not cleared between operations.
- R6: The write sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x20 enters shortcut mode. In this mode a write of 0xA0 followed by an address/data write programs a byte. The writes 0x90 then 0x00 leave the mode. After leaving, a bare 0xA0 write no longer starts a program.
- R7: Sector erase is 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then 0x30 at any address in the sector. The sector is the top log2(NUM_SECT) bits of the array index, which are address bits 5..4 by default. The erase first clears every byte in the sector to 0x00 and then sets every byte to 0xFF. Bytes in other sectors are unchanged.
- R8: When bit s of `prot_mask` is 1, a program or erase aimed at sector s is dropped. `ready` stays 1 and the data is unchanged.
- R9: While `low_vcc` is 1, write cycles are ignored entirely.
- R10: A write that breaks a command sequence, including 0xF0, returns the machine to read mode. A complete unlock is then needed again.
- R11: Write cycles issued while busy are ignored. They neither lengthen the operation nor advance a command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address for command and array access |
| wdata | input | 8 | Write data / command code |
| low_vcc | input | 1 | Low-supply indicator; 1 blocks all writes |
| prot_mask | input | NUM_SECT | Per-sector protect, 1 = protected |
| rdata | output | 8 | Registered read data or status byte |
| ready | output | 1 | 1 = idle, 0 = program or erase running |

## Verification
Read data is due one clock after the read cycle is driven, because `rdata` is a single register. The bench therefore records which edges sampled a read and compares `rdata` at the following falling edge. `ready` follows the state register, so it is checked low at the falling edge right after the final command write. The bench then counts falling edges with `ready` low, and that count must equal PROG_CYC or PRE_CYC+ERASE_CYC. When a command must be ignored, the bench samples `ready` at the falling edge after the write that would have launched it. A later read then shows that the array byte is unchanged.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [3:0] {
        ST_READ  = 4'd0,
        ST_UNL1  = 4'd1,
        ST_UNL2  = 4'd2,
        ST_PGM   = 4'd3,
        ST_ER0   = 4'd4,
        ST_ER1   = 4'd5,
        ST_ER2   = 4'd6,
        ST_BYX   = 4'd7,
        ST_PROG  = 4'd8,
        ST_PRE   = 4'd9,
        ST_ERASE = 4'd10
    } nfc_st_e;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_BYP_ON = 8'h20;
    localparam logic [7:0] CODE_BYP_X1 = 8'h90;
    localparam logic [7:0] CODE_BYP_X2 = 8'h00;
endpackage

// File: rtl/nfc_bus_decode.sv
module nfc_bus_decode (
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic low_vcc,
    output logic wr_stb,
    output logic rd_stb
);
    always_comb begin
        wr_stb = !ce_n && !we_n && oe_n && !low_vcc;
        rd_stb = !ce_n && !oe_n && we_n;
    end
endmodule

// File: rtl/nfc_sect_guard.sv
module nfc_sect_guard #(
    parameter int NUM_SECT = 4,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic [SECT_W-1:0]   sect_idx,
    input  logic [NUM_SECT-1:0] prot_mask,
    output logic                blocked
);
    always_comb blocked = prot_mask[sect_idx];
endmodule

// File: rtl/nfc_status_fmt.sv
module nfc_status_fmt (
    input  logic       is_prog,
    input  logic       prog_msb,
    input  logic       tgl,
    output logic [7:0] status
);
    always_comb begin
        status    = 8'h00;
        status[7] = is_prog ? !prog_msb : 1'b0;
        status[6] = tgl;
    end
endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd #(
    parameter int ADDR_W              = 11,
    parameter int DEPTH               = 64,
    parameter int NUM_SECT            = 4,
    parameter int PROG_CYC            = 6,
    parameter int PRE_CYC             = 5,
    parameter int ERASE_CYC           = 9,
    parameter logic [ADDR_W-1:0] KEY_ADDR1 = 11'h555,
    parameter logic [ADDR_W-1:0] KEY_ADDR2 = 11'h2AA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    input  logic                low_vcc,
    input  logic [NUM_SECT-1:0] prot_mask,
    output logic [7:0]          rdata,
    output logic                ready
);
    import nfc_pkg::*;

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int SECT_W  = $clog2(NUM_SECT);
    localparam int MAX_CYC = (PROG_CYC > PRE_CYC) ?
                             ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) :
                             ((PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        nfc_st_e           state;
        logic [CNT_W-1:0]  cnt;
        logic              bypass;
        logic              tgl;
        logic [7:0]        rdata;
        logic [IDX_W-1:0]  paddr;
        logic [7:0]        pdata;
        logic [SECT_W-1:0] sect;
    } regs_t;

    regs_t      reg_d, reg_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    logic             wr_stb, rd_stb, blocked, busy;
    logic [7:0]       status;
    logic [IDX_W-1:0] cmd_idx;
    logic [SECT_W-1:0] cmd_sect;

    assign cmd_idx  = addr[IDX_W-1:0];
    assign cmd_sect = cmd_idx[IDX_W-1 -: SECT_W];
    assign busy     = (reg_q.state == ST_PROG) || (reg_q.state == ST_PRE) ||
                      (reg_q.state == ST_ERASE);

    nfc_bus_decode bus_i (
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .low_vcc(low_vcc),
        .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    nfc_sect_guard #(.NUM_SECT(NUM_SECT)) guard_i (
        .sect_idx(cmd_sect), .prot_mask(prot_mask), .blocked(blocked)
    );

    nfc_status_fmt fmt_i (
        .is_prog(reg_q.state == ST_PROG), .prog_msb(reg_q.pdata[7]),
        .tgl(reg_q.tgl), .status(status)
    );

    always_comb begin
        logic key1, key2;
        logic [IDX_W-1:0] iv;
        reg_d = reg_q;
        mem_d = mem_q;
        iv    = '0;
        key1  = (addr == KEY_ADDR1) && (wdata == CODE_KEY1);
        key2  = (addr == KEY_ADDR2) && (wdata == CODE_KEY2);

        if (rd_stb) begin
            if (busy) begin
                reg_d.rdata = status;
                reg_d.tgl   = !reg_q.tgl;
            end else begin
                reg_d.rdata = mem_q[cmd_idx];
            end
        end

        case (reg_q.state)
            ST_READ: if (wr_stb) begin
                if (reg_q.bypass) begin
                    if (wdata == CODE_PROG)        reg_d.state = ST_PGM;
                    else if (wdata == CODE_BYP_X1) reg_d.state = ST_BYX;
                end else if (key1) begin
                    reg_d.state = ST_UNL1;
                end
            end
            ST_UNL1: if (wr_stb) reg_d.state = key2 ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_stb) begin
                reg_d.state = ST_READ;
                if (addr == KEY_ADDR1) begin
                    if (wdata == CODE_PROG)        reg_d.state = ST_PGM;
                    else if (wdata == CODE_ERASE)  reg_d.state = ST_ER0;
                    else if (wdata == CODE_BYP_ON) reg_d.bypass = 1'b1;
                end
            end
            ST_PGM: if (wr_stb) begin
                reg_d.state = ST_READ;
                if (!blocked) begin
                    reg_d.state = ST_PROG;
                    reg_d.paddr = cmd_idx;
                    reg_d.pdata = wdata;
                    reg_d.cnt   = CNT_W'(PROG_CYC - 1);
                end
            end
            ST_ER0: if (wr_stb) reg_d.state = key1 ? ST_ER1 : ST_READ;
            ST_ER1: if (wr_stb) reg_d.state = key2 ? ST_ER2 : ST_READ;
            ST_ER2: if (wr_stb) begin
                reg_d.state = ST_READ;
                if (wdata == CODE_SECT && !blocked) begin
                    reg_d.state = ST_PRE;
                    reg_d.sect  = cmd_sect;
                    reg_d.cnt   = CNT_W'(PRE_CYC - 1);
                end
            end
            ST_BYX: if (wr_stb) begin
                reg_d.state = ST_READ;
                if (wdata == CODE_BYP_X2) reg_d.bypass = 1'b0;
            end
            ST_PROG: begin
                if (reg_q.cnt == '0) begin
                    mem_d[reg_q.paddr] = mem_q[reg_q.paddr] & reg_q.pdata;
                    reg_d.state = ST_READ;
                end else begin
                    reg_d.cnt = reg_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (reg_q.cnt == '0) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        iv = IDX_W'(i);
                        if (iv[IDX_W-1 -: SECT_W] == reg_q.sect) mem_d[i] = 8'h00;
                    end
                    reg_d.state = ST_ERASE;
                    reg_d.cnt   = CNT_W'(ERASE_CYC - 1);
                end else begin
                    reg_d.cnt = reg_q.cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (reg_q.cnt == '0) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        iv = IDX_W'(i);
                        if (iv[IDX_W-1 -: SECT_W] == reg_q.sect) mem_d[i] = 8'hFF;
                    end
                    reg_d.state = ST_READ;
                end else begin
                    reg_d.cnt = reg_q.cnt - 1'b1;
                end
            end
            default: reg_d.state = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            reg_q <= reg_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = reg_q.rdata;
    assign ready = !busy;
endmodule

// File: rtl/nor_flash_cmd_chk.sv
module nor_flash_cmd_chk #(
    parameter int PROG_CYC  = 6,
    parameter int PRE_CYC   = 5,
    parameter int ERASE_CYC = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ce_n,
    input logic           we_n,
    input logic           oe_n,
    input logic           low_vcc,
    input logic [7:0]     rdata,
    input logic           ready,
    input nfc_pkg::nfc_st_e state,
    input logic           prog_msb
);
    import nfc_pkg::*;

    logic        rd, wr_raw, seen_q;
    logic [15:0] blen_q;

    assign rd     = !ce_n && !oe_n && we_n;
    assign wr_raw = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blen_q <= '0;
            seen_q <= 1'b0;
        end else begin
            blen_q <= ready ? 16'd0 : blen_q + 16'd1;
            seen_q <= ready ? 1'b0 : (seen_q || rd);
        end
    end

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (blen_q == 16'(PROG_CYC) || blen_q == 16'(PRE_CYC + ERASE_CYC)));

    p_dq7_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && state == ST_PROG) |=> (rdata[7] != $past(prog_msb)));

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ready && seen_q) |=> (rdata[6] != $past(rdata[6])));

    p_lowvcc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && low_vcc && state == ST_READ) |=> (state == ST_READ && ready));
endmodule

bind nor_flash_cmd nor_flash_cmd_chk #(
    .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .low_vcc(low_vcc), .rdata(rdata), .ready(ready),
    .state(reg_q.state), .prog_msb(reg_q.pdata[7])
);

// File: tb/nor_flash_cmd_tb_top.sv
module nor_flash_cmd_tb_top;
    localparam int PROG_CYC  = 6;
    localparam int PRE_CYC   = 5;
    localparam int ERASE_CYC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        low_vcc = 1'b0;
    logic [3:0]  prot_mask = '0;
    logic [7:0]  rdata;
    logic        ready;

    int vectors = 0;
    int miscomp = 0;
    bit done = 0;
    bit tgl_m = 0;
    bit rd_edge = 0;

    logic [7:0] q_val [$];
    string      q_tag [$];

    always #4 clk = !clk;

    nor_flash_cmd #(.PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .low_vcc(low_vcc), .prot_mask(prot_mask),
        .rdata(rdata), .ready(ready)
    );

    task automatic check(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value one cycle after the read edge
    always @(posedge clk) rd_edge <= rst_n && !ce_n && !oe_n && we_n;
    always @(negedge clk) begin
        if (rd_edge) begin
            if (q_val.size() == 0) begin
                vectors++; miscomp++;
                $display("FAIL R1: actual read with no expected item, expected none");
            end else begin
                check(int'(rdata), int'(q_val.pop_front()), q_tag.pop_front());
            end
        end
    end

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        q_val.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic unlock();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    // runs while busy; status reads and an optional write injected during busy
    task automatic busy_run(input int exp_len, input int nreads, input bit b7,
                            input bit inject, input string tag);
        int n = 0;
        check(int'(ready), 0, tag);
        while (ready == 1'b0 && n < 1000) begin
            if (n < nreads) begin
                ce_n = 0; oe_n = 0; we_n = 1; addr = '0;
                q_val.push_back({b7, tgl_m, 6'b0});
                q_tag.push_back("R4/R5 status");
                tgl_m = !tgl_m;
            end else if (inject && n == nreads) begin
                ce_n = 0; we_n = 0; oe_n = 1; addr = 11'h555; wdata = 8'hAA;
            end
            n++;
            @(negedge clk);
            ce_n = 1; oe_n = 1; we_n = 1;
        end
        check(n, exp_len, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(int'(ready), 1, "R1 ready after reset");
        rd(11'h005, 8'hFF, "R1 erased after reset");

        // R2 four-cycle program, R3 busy window, R4 status bit7
        unlock(); wr(11'h555, 8'hA0); wr(11'h005, 8'h3C);
        busy_run(PROG_CYC, 2, 1'b1, 1'b0, "R3 program busy length");
        rd(11'h005, 8'h3C, "R2 programmed byte");

        // R2 AND semantics, R11 write during busy ignored
        unlock(); wr(11'h555, 8'hA0); wr(11'h005, 8'hF0);
        busy_run(PROG_CYC, 0, 1'b0, 1'b1, "R11 busy length with write");
        rd(11'h005, 8'h30, "R2 program only clears bits");
        wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h005, 8'h00);
        check(int'(ready), 1, "R11 write during busy did not unlock");
        rd(11'h005, 8'h30, "R11 byte unchanged");

        // R6 shortcut mode
        unlock(); wr(11'h555, 8'h20);
        wr(11'h555, 8'hA0); wr(11'h012, 8'h81);
        busy_run(PROG_CYC, 2, 1'b0, 1'b0, "R6 shortcut program busy");
        rd(11'h012, 8'h81, "R6 shortcut program data");
        wr(11'h555, 8'h90); wr(11'h000, 8'h00);
        wr(11'h555, 8'hA0); wr(11'h014, 8'h00);
        check(int'(ready), 1, "R6 exit blocks bare A0");
        rd(11'h014, 8'hFF, "R6 exit byte unchanged");

        // R7 sector erase
        unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h003, 8'h30);
        busy_run(PRE_CYC + ERASE_CYC, 2, 1'b0, 1'b0, "R7 erase busy length");
        rd(11'h005, 8'hFF, "R7 sector erased");
        rd(11'h012, 8'h81, "R7 other sector untouched");

        // R8 protection
        prot_mask = 4'b0010;
        unlock(); wr(11'h555, 8'hA0); wr(11'h013, 8'h00);
        check(int'(ready), 1, "R8 protected program ignored");
        rd(11'h013, 8'hFF, "R8 protected byte unchanged");
        unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h010, 8'h30);
        check(int'(ready), 1, "R8 protected erase ignored");
        rd(11'h012, 8'h81, "R8 protected sector unchanged");
        prot_mask = 4'b0000;

        // R9 low supply
        low_vcc = 1;
        unlock(); wr(11'h555, 8'hA0); wr(11'h020, 8'h00);
        check(int'(ready), 1, "R9 low supply blocks program");
        low_vcc = 0;
        rd(11'h020, 8'hFF, "R9 byte unchanged");

        // R10 broken sequences
        wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'h021, 8'h00);
        check(int'(ready), 1, "R10 wrong address aborts");
        wr(11'h555, 8'hAA); wr(11'h555, 8'hF0);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h021, 8'h00);
        check(int'(ready), 1, "R10 reset code aborts");
        rd(11'h021, 8'hFF, "R10 byte unchanged");
        unlock(); wr(11'h555, 8'hA0); wr(11'h021, 8'h5A);
        busy_run(PROG_CYC, 0, 1'b0, 1'b0, "R10 full unlock works");
        rd(11'h021, 8'h5A, "R10 programmed after full unlock");

        repeat (2) @(negedge clk);
        check(q_val.size(), 0, "R1 all reads returned");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule